// File: doc/BRIEF.md
# Segment Table Address Translator

The block turns a logical address (a segment number plus an offset) into a physical address. It keeps an on-chip table with one entry per segment. Each entry holds a base address, a length, three permission flags and a present flag. For each request, the block adds the base to the offset and compares the offset with the length at the same time. It also checks the requested kind of access against the entry's permission flags. The result is either a physical address or a two-bit fault code.

Only privileged software can change the table, through a dedicated write port. A write made while the privilege input is low is dropped. Requests enter on a valid/ready channel and results leave on a valid/ready channel one cycle after acceptance.

Back-pressure rules:
- The request side is ready whenever the single result register is empty, or is being drained in that same cycle.
- A result that is not taken stays on the outputs unchanged.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset `rsp_valid_o` is low, `req_ready_o` is high, and every table entry is non-present, so any request returns fault 01.
- R2: When `tw_en_i` and `priv_i` are both high at a clock edge, entry `tw_idx_i` takes the base, length, permissions and present flag on the write port. Requests accepted on later edges use the new entry.
- R3: A table write with `priv_i` low changes no entry.
- R4: A request to a present segment with offset below the length, for an access the entry permits, returns fault 00 and address (base + offset) modulo 2^PA_W.
- R5: A request to a non-present segment returns fault 01, whatever its offset and access kind.
- R6: A request to a present segment with offset greater than or equal to the length returns fault 10. This holds even when the access kind is also not permitted.
- R7: A request that passes the present and length checks but is not permitted returns fault 11. Access code 00 needs permission bit 0 (read), 01 needs bit 1 (write), 10 needs bit 2 (execute). Code 11 is never permitted.
- R8: Any response with a non-zero fault code carries address zero.
- R9: A request accepted at a clock edge (`req_valid_i` and `req_ready_o` high) has its response on the outputs with `rsp_valid_o` high right after that edge. `rsp_valid_o` never rises without an accepted request.
- R10: While `rsp_valid_o` is high and `rsp_ready_i` is low:
  - `req_ready_o` is low.
  - The response outputs hold their values.
  - When the response is taken, a new request can be accepted in the same cycle.
- R11: A request accepted at the same edge as a table write to its segment is translated with the entry as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 1 | Privileged mode; gates table writes |
| tw_en_i | input | 1 | Table write strobe |
| tw_idx_i | input | SEG_W | Entry to write |
| tw_base_i | input | PA_W | Segment base address |
| tw_limit_i | input | OFF_W+1 | Segment length in address units |
| tw_perm_i | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| tw_present_i | input | 1 | Entry present flag |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_seg_i | input | SEG_W | Segment number |
| req_off_i | input | OFF_W | Offset in segment |
| req_acc_i | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_pa_o | output | PA_W | Physical address (zero on fault) |
| rsp_fault_o | output | 2 | 00 ok, 01 absent segment, 10 out of range, 11 not permitted |

## Verification
The bench uses the default parameters: 8 segments, 13-bit offsets and a 16-bit physical address. These sizes let a single base plus maximum-offset case overflow the physical width, so the wrap-around can be checked directly. A full-length segment (length 8192) exercises the extra length bit. A zero-length segment exercises the range check at its lower edge. The narrow address also puts every fault priority pairing within a short vector table.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_RANGE  = 2'b10,
    FLT_PERM   = 2'b11
  } flt_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  localparam int PERM_W  = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 13,
  parameter int PA_W  = 16,
  localparam int NSEG  = 1 << SEG_W,
  localparam int LIM_W = OFF_W + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             wr_priv,
  input  logic [SEG_W-1:0]                 wr_idx,
  input  logic [PA_W-1:0]                  wr_base,
  input  logic [LIM_W-1:0]                 wr_limit,
  input  logic [seg_xlate_pkg::PERM_W-1:0] wr_perm,
  input  logic                             wr_present,
  input  logic [SEG_W-1:0]                 rd_idx,
  output logic [PA_W-1:0]                  rd_base,
  output logic [LIM_W-1:0]                 rd_limit,
  output logic [seg_xlate_pkg::PERM_W-1:0] rd_perm,
  output logic                             rd_present,
  output logic [NSEG-1:0]                  present_vec
);

  logic [PA_W-1:0]                  base_q  [NSEG];
  logic [LIM_W-1:0]                 limit_q [NSEG];
  logic [seg_xlate_pkg::PERM_W-1:0] perm_q  [NSEG];
  logic [NSEG-1:0]                  pres_q;

  logic wr_go;
  assign wr_go = wr_en & wr_priv;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic hit;
    assign hit = wr_go && (wr_idx == SEG_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        perm_q[g]  <= '0;
        pres_q[g]  <= 1'b0;
      end else if (hit) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
        perm_q[g]  <= wr_perm;
        pres_q[g]  <= wr_present;
      end
    end
  end

  assign rd_base     = base_q[rd_idx];
  assign rd_limit    = limit_q[rd_idx];
  assign rd_perm     = perm_q[rd_idx];
  assign rd_present  = pres_q[rd_idx];
  assign present_vec = pres_q;

endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int OFF_W = 13,
  parameter int PA_W  = 16,
  localparam int LIM_W = OFF_W + 1
) (
  input  logic [PA_W-1:0]                  ent_base,
  input  logic [LIM_W-1:0]                 ent_limit,
  input  logic [seg_xlate_pkg::PERM_W-1:0] ent_perm,
  input  logic                             ent_present,
  input  logic [OFF_W-1:0]                 off,
  input  seg_xlate_pkg::acc_e              acc,
  output seg_xlate_pkg::flt_e              fault,
  output logic [PA_W-1:0]                  pa
);
  import seg_xlate_pkg::*;

  logic [PA_W-1:0] sum;
  logic            in_range;
  logic            allowed;

  // Add and compare run side by side; the fault picks the result.
  assign sum      = ent_base + PA_W'(off);
  assign in_range = {1'b0, off} < ent_limit;

  always_comb begin
    unique case (acc)
      ACC_RD:  allowed = ent_perm[PERM_RD];
      ACC_WR:  allowed = ent_perm[PERM_WR];
      ACC_EX:  allowed = ent_perm[PERM_EX];
      default: allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!ent_present)   fault = FLT_ABSENT;
    else if (!in_range) fault = FLT_RANGE;
    else if (!allowed)  fault = FLT_PERM;
    else                fault = FLT_NONE;
  end

  assign pa = (fault == FLT_NONE) ? sum : '0;

endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg #(
  parameter int PA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  seg_xlate_pkg::flt_e in_fault,
  input  logic [PA_W-1:0]     in_pa,
  output logic                out_valid,
  input  logic                out_ready,
  output seg_xlate_pkg::flt_e out_fault,
  output logic [PA_W-1:0]     out_pa
);
  import seg_xlate_pkg::*;

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= FLT_NONE;
      out_pa    <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_fault <= in_fault;
        out_pa    <= in_pa;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 13,
  parameter int PA_W  = 16,
  localparam int NSEG  = 1 << SEG_W,
  localparam int LIM_W = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv_i,
  input  logic             tw_en_i,
  input  logic [SEG_W-1:0] tw_idx_i,
  input  logic [PA_W-1:0]  tw_base_i,
  input  logic [LIM_W-1:0] tw_limit_i,
  input  logic [2:0]       tw_perm_i,
  input  logic             tw_present_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [SEG_W-1:0] req_seg_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [1:0]       req_acc_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic [1:0]       rsp_fault_o
);
  import seg_xlate_pkg::*;

  logic [PA_W-1:0]   ent_base;
  logic [LIM_W-1:0]  ent_limit;
  logic [PERM_W-1:0] ent_perm;
  logic              ent_present;
  logic [NSEG-1:0]   seg_present_vec;
  flt_e              chk_fault;
  logic [PA_W-1:0]   chk_pa;
  flt_e              out_fault;

  seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (tw_en_i),
    .wr_priv     (priv_i),
    .wr_idx      (tw_idx_i),
    .wr_base     (tw_base_i),
    .wr_limit    (tw_limit_i),
    .wr_perm     (tw_perm_i),
    .wr_present  (tw_present_i),
    .rd_idx      (req_seg_i),
    .rd_base     (ent_base),
    .rd_limit    (ent_limit),
    .rd_perm     (ent_perm),
    .rd_present  (ent_present),
    .present_vec (seg_present_vec)
  );

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .ent_base    (ent_base),
    .ent_limit   (ent_limit),
    .ent_perm    (ent_perm),
    .ent_present (ent_present),
    .off         (req_off_i),
    .acc         (acc_e'(req_acc_i)),
    .fault       (chk_fault),
    .pa          (chk_pa)
  );

  seg_rsp_reg #(.PA_W(PA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid_i),
    .in_ready  (req_ready_o),
    .in_fault  (chk_fault),
    .in_pa     (chk_pa),
    .out_valid (rsp_valid_o),
    .out_ready (rsp_ready_i),
    .out_fault (out_fault),
    .out_pa    (rsp_pa_o)
  );

  assign rsp_fault_o = out_fault;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 3,
  parameter int PA_W  = 16,
  localparam int NSEG = 1 << SEG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             priv_i,
  input logic             tw_en_i,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [SEG_W-1:0] req_seg_i,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [PA_W-1:0]  rsp_pa_o,
  input logic [1:0]       rsp_fault_o,
  input logic [NSEG-1:0]  seg_present_vec
);

  logic acc_q;
  assign acc_q = req_valid_i && req_ready_o;

  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_fault_o != 2'b00) |-> (rsp_pa_o == '0)); // R8

  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> rsp_valid_o); // R9

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid_o && !acc_q) |=> !rsp_valid_o); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_fault_o))); // R10

  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o); // R10

  AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !(tw_en_i && priv_i) |=> $stable(seg_present_vec)); // R3

  AST_ABSENT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !seg_present_vec[req_seg_i]) |=> (rsp_fault_o == 2'b01)); // R5

endmodule

bind seg_xlate_top seg_xlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .priv_i          (priv_i),
  .tw_en_i         (tw_en_i),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_seg_i       (req_seg_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_ready_i     (rsp_ready_i),
  .rsp_pa_o        (rsp_pa_o),
  .rsp_fault_o     (rsp_fault_o),
  .seg_present_vec (seg_present_vec)
);

// File: tb/seg_xlate_top_tb.sv
module seg_xlate_top_tb;

  localparam int SEG_W = 3;
  localparam int OFF_W = 13;
  localparam int PA_W  = 16;
  localparam int LIM_W = OFF_W + 1;
  localparam int NV    = 13;

  // vector: {seg[3], off[13], acc[2], fault[2], pa[16]}
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 13'h00FF, 2'd0, 2'd0, 16'h10FF},  // R4 last in-range read
    {3'd0, 13'h0100, 2'd0, 2'd2, 16'h0000},  // R6 offset == length
    {3'd0, 13'h0010, 2'd1, 2'd3, 16'h0000},  // R7 write to read/exec segment
    {3'd0, 13'h0020, 2'd2, 2'd0, 16'h1020},  // R4 execute
    {3'd1, 13'h1FFF, 2'd1, 2'd0, 16'h0FFF},  // R4 wrap around
    {3'd1, 13'h0000, 2'd2, 2'd3, 16'h0000},  // R7 exec not allowed
    {3'd2, 13'h0000, 2'd0, 2'd2, 16'h0000},  // R6 zero-length segment
    {3'd3, 13'h0000, 2'd0, 2'd1, 16'h0000},  // R5 absent
    {3'd5, 13'h1FFF, 2'd2, 2'd1, 16'h0000},  // R5 absent, also out of range
    {3'd4, 13'h000F, 2'd1, 2'd0, 16'h400F},  // R4 write-only segment
    {3'd4, 13'h0010, 2'd0, 2'd2, 16'h0000},  // R6 range beats permission
    {3'd4, 13'h0003, 2'd0, 2'd3, 16'h0000},  // R7 read of write-only
    {3'd1, 13'h0005, 2'd3, 2'd3, 16'h0000}   // R7 reserved access code
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             priv_i = 1'b0;
  logic             tw_en_i = 1'b0;
  logic [SEG_W-1:0] tw_idx_i = '0;
  logic [PA_W-1:0]  tw_base_i = '0;
  logic [LIM_W-1:0] tw_limit_i = '0;
  logic [2:0]       tw_perm_i = '0;
  logic             tw_present_i = 1'b0;
  logic             req_valid_i = 1'b0;
  logic             req_ready_o;
  logic [SEG_W-1:0] req_seg_i = '0;
  logic [OFF_W-1:0] req_off_i = '0;
  logic [1:0]       req_acc_i = '0;
  logic             rsp_valid_o;
  logic             rsp_ready_i = 1'b1;
  logic [PA_W-1:0]  rsp_pa_o;
  logic [1:0]       rsp_fault_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  seg_xlate_top #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic priv, input int idx, input logic [15:0] base,
                    input logic [13:0] lim, input logic [2:0] perm, input logic pres);
    @(negedge clk);
    priv_i = priv; tw_en_i = 1'b1; tw_idx_i = SEG_W'(idx);
    tw_base_i = base; tw_limit_i = lim; tw_perm_i = perm; tw_present_i = pres;
    @(negedge clk);
    tw_en_i = 1'b0; priv_i = 1'b0;
  endtask

  // one request, sampled at the negedge after the accepting posedge
  task automatic xl(input int seg, input logic [12:0] off, input logic [1:0] acc,
                    output logic [17:0] res);
    @(negedge clk);
    req_valid_i = 1'b1; req_seg_i = SEG_W'(seg); req_off_i = off; req_acc_i = acc;
    @(negedge clk);
    req_valid_i = 1'b0;
    res = {rsp_fault_o, rsp_pa_o};
    if (!rsp_valid_o) begin
      checks++; failures++;
      $display("FAIL R9 actual=rsp_valid 0 expected=1");
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [17:0] r;
    logic [17:0] held;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid", 32'(rsp_valid_o), 32'd0);
    chk("R1 req_ready", 32'(req_ready_o), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after release", 32'(rsp_valid_o), 32'd0);
    xl(0, 13'h0, 2'd0, r);
    chk("R1 empty table", 32'(r[17:16]), 32'd1);

    // user-mode write must not land
    wr(1'b0, 3, 16'h2000, 14'h0100, 3'b111, 1'b1);
    xl(3, 13'h0, 2'd0, r);
    chk("R3 user write ignored", 32'(r), {14'd0, 2'd1, 16'h0});

    // R2 programming
    wr(1'b1, 0, 16'h1000, 14'h0100, 3'b101, 1'b1);
    wr(1'b1, 1, 16'hF000, 14'h2000, 3'b011, 1'b1);
    wr(1'b1, 2, 16'h0200, 14'h0000, 3'b111, 1'b1);
    wr(1'b1, 4, 16'h4000, 14'h0010, 3'b010, 1'b1);

    for (int i = 0; i < NV; i++) begin
      xl(int'(VEC[i][35:33]), VEC[i][32:20], VEC[i][19:18], r);
      chk($sformatf("R4-vector %0d (R5 R6 R7 R8)", i), 32'(r), 32'(VEC[i][17:0]));
    end

    // R2 overwrite an entry
    wr(1'b1, 0, 16'h3000, 14'h0040, 3'b001, 1'b1);
    xl(0, 13'h003F, 2'd0, r);
    chk("R2 overwrite base", 32'(r), {14'd0, 2'd0, 16'h303F});
    xl(0, 13'h0040, 2'd0, r);
    chk("R2 overwrite length", 32'(r[17:16]), 32'd2);

    // R11 same-edge write and request
    @(negedge clk);
    priv_i = 1'b1; tw_en_i = 1'b1; tw_idx_i = 3'd6; tw_base_i = 16'h0800;
    tw_limit_i = 14'h0020; tw_perm_i = 3'b001; tw_present_i = 1'b1;
    req_valid_i = 1'b1; req_seg_i = 3'd6; req_off_i = 13'h4; req_acc_i = 2'd0;
    @(negedge clk);
    tw_en_i = 1'b0; priv_i = 1'b0; req_valid_i = 1'b0;
    chk("R11 old entry used", 32'({rsp_fault_o, rsp_pa_o}), {14'd0, 2'd1, 16'h0});
    xl(6, 13'h4, 2'd0, r);
    chk("R11 new entry afterwards", 32'(r), {14'd0, 2'd0, 16'h0804});

    // R10 back-pressure
    @(negedge clk);
    rsp_ready_i = 1'b0;
    req_valid_i = 1'b1; req_seg_i = 3'd1; req_off_i = 13'h10; req_acc_i = 2'd0;
    @(negedge clk);
    held = {rsp_fault_o, rsp_pa_o};
    chk("R10 first response", 32'(held), {14'd0, 2'd0, 16'hF010});
    req_seg_i = 3'd7; req_off_i = 13'h0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 stall valid", 32'(rsp_valid_o), 32'd1);
      chk("R10 stall not ready", 32'(req_ready_o), 32'd0);
      chk("R10 stall hold", 32'({rsp_fault_o, rsp_pa_o}), 32'(held));
    end
    rsp_ready_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R10 drain and refill", 32'({rsp_valid_o, rsp_fault_o}), {29'd0, 3'b101});
    @(negedge clk);
    chk("R9 idle after drain", 32'(rsp_valid_o), 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule